// File: doc/BRIEF.md
# Nibble Pointer Register Exchange Unit

This block is the register slice of a 4-bit controller datapath. It holds an accumulator, a data pointer split into a high nibble and a low nibble, four general working registers, and two small save banks: one for the high pointer nibble and one for the low pointer nibble. A one-byte instruction code, qualified by a valid strobe, can load immediate values into the pointer, step the low pointer nibble up or down, move values between the accumulator and the low pointer nibble, or swap a register with one of its partners. All of these take one clock.

A zero flag follows the result of the step instructions and of the copy from the pointer into the accumulator. Every register is visible on the output ports, so the surrounding datapath (memory addressing, arithmetic unit, sequencer) can read the pointer and accumulator directly. Instruction codes outside this group change nothing.

Top module: `dp_xchg_unit`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, both pointer nibbles, all working and save registers, and the zero flag; the cleared state is visible after the first rising edge with reset high.
- R2: Code 1000iiii clears the high pointer nibble and loads iiii into the low pointer nibble; the zero flag is unchanged.
- R3: Code 0100iiii loads iiii into the high pointer nibble; the low nibble and the zero flag are unchanged.
- R4: Code 0xEE adds one to the low pointer nibble modulo 16 (0xF becomes 0x0) and sets the zero flag exactly when the result is 0.
- R5: Code 0xEF subtracts one from the low pointer nibble modulo 16 (0x0 becomes 0xF) and sets the zero flag exactly when the result is 0.
- R6: Code 0xF7 copies the accumulator into the low pointer nibble; the zero flag is unchanged.
- R7: Code 0xE9 copies the low pointer nibble into the accumulator and sets the zero flag exactly when the copied value is 0.
- R8: Code 0x23 swaps the accumulator and the high pointer nibble.
- R9: Code 111000ss (0xE0, 0xE4, 0xE8, 0xEC) swaps the accumulator with working register ss, where ss is bits 3..2; working register k appears on work_regs bits 4k+3..4k.
- R10: Code 1111100s (0xF8, 0xF9) swaps the high pointer nibble with high save register s; save register k appears on save_hi bits 4k+3..4k.
- R11: Code 1111110s (0xFC, 0xFD) swaps the low pointer nibble with low save register s; save register k appears on save_lo bits 4k+3..4k.
- R12: With instr_valid low no register or flag changes; with it high the result is visible after the next rising edge.
- R13: Any code not listed in R2 to R11 leaves every register and the zero flag unchanged, and only R4, R5 and R7 change the zero flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Qualifies opcode for this cycle |
| opcode | input | 8 | Instruction code |
| ac_out | output | 4 | Accumulator |
| dph_out | output | 4 | High pointer nibble |
| dpl_out | output | 4 | Low pointer nibble |
| work_regs | output | 16 | Working registers 0..3, register k at bits 4k+3..4k |
| save_hi | output | 8 | High save registers 0..1, register k at bits 4k+3..4k |
| save_lo | output | 8 | Low save registers 0..1, register k at bits 4k+3..4k |
| zero_flag | output | 1 | Zero flag |

## Verification
Every result of this block is due exactly one rising edge after the instruction is presented: there is one register stage between opcode and every output, including both halves of a swap and the zero flag. The bench pushes the full expected register image for each presented code into a queue at the falling edge where it drives the code, and the monitor pops and compares one image a short delay after each following rising edge, so each comparison lands on the cycle the instruction completes. Idle cycles and illegal codes push an unchanged image, so an unwanted update is seen on the same edge it would occur.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

    localparam int NIB_W  = 4;
    localparam int OPC_W  = 8;
    localparam int N_WORK = 4;
    localparam int N_SAVE = 2;
    localparam int WSEL_W = $clog2(N_WORK);
    localparam int SSEL_W = (N_SAVE > 1) ? $clog2(N_SAVE) : 1;

    typedef logic [NIB_W-1:0] nib_t;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_LDZ,
        OP_LHI,
        OP_INC,
        OP_DEC,
        OP_AC2DL,
        OP_DL2AC,
        OP_XAH,
        OP_XAW,
        OP_XHS,
        OP_XLS
    } op_e;

    typedef struct packed {
        op_e               op;
        nib_t              imm;
        logic [WSEL_W-1:0] wsel;
        logic [SSEL_W-1:0] ssel;
    } dec_t;

    typedef struct packed {
        nib_t ac;
        nib_t dph;
        nib_t dpl;
        logic zf;
    } core_t;

    function automatic dec_t decode_op(input logic [OPC_W-1:0] code);
        dec_t d;
        d.op   = OP_NONE;
        d.imm  = code[NIB_W-1:0];
        d.wsel = code[2 +: WSEL_W];
        d.ssel = code[SSEL_W-1:0];
        if (code[7:4] == 4'b1000)
            d.op = OP_LDZ;
        else if (code[7:4] == 4'b0100)
            d.op = OP_LHI;
        else if (code[7:4] == 4'b1110 && code[1:0] == 2'b00)
            d.op = OP_XAW;
        else if (code[7:1] == 7'b1111100)
            d.op = OP_XHS;
        else if (code[7:1] == 7'b1111110)
            d.op = OP_XLS;
        else begin
            case (code)
                8'hEE:   d.op = OP_INC;
                8'hEF:   d.op = OP_DEC;
                8'hF7:   d.op = OP_AC2DL;
                8'hE9:   d.op = OP_DL2AC;
                8'h23:   d.op = OP_XAH;
                default: d.op = OP_NONE;
            endcase
        end
        return d;
    endfunction

    function automatic nib_t nib_step(input nib_t v, input logic down);
        return down ? nib_t'(v - 1'b1) : nib_t'(v + 1'b1);
    endfunction

    function automatic logic nib_is_zero(input nib_t v);
        return (v == '0);
    endfunction

endpackage

// File: rtl/dpx_decoder.sv
module dpx_decoder
    import dpx_pkg::*;
(
    input  logic             valid,
    input  logic [OPC_W-1:0] code,
    output dec_t             dec
);

    always_comb begin
        dec = decode_op(code);
        if (!valid) dec.op = OP_NONE;
    end

endmodule

// File: rtl/dpx_bank.sv
module dpx_bank #(
    parameter int DEPTH = 2,
    parameter int W     = 4,
    parameter int SEL_W = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [SEL_W-1:0]   sel,
    input  logic [W-1:0]       wdata,
    output logic [W-1:0]       rdata,
    output logic [DEPTH*W-1:0] flat
);

    logic [W-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot[i] <= '0;
            else if (we && sel == SEL_W'(i))
                slot[i] <= wdata;
        end
        assign flat[i*W +: W] = slot[i];
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < DEPTH; k++)
            if (sel == SEL_W'(k)) rdata = slot[k];
    end

endmodule

// File: rtl/dpx_exec.sv
module dpx_exec
    import dpx_pkg::*;
(
    input  core_t cur,
    input  dec_t  dec,
    input  nib_t  w_rd,
    input  nib_t  h_rd,
    input  nib_t  l_rd,
    output core_t nxt,
    output logic  w_we,
    output logic  h_we,
    output logic  l_we,
    output nib_t  w_wd,
    output nib_t  h_wd,
    output nib_t  l_wd
);

    nib_t stepped;

    always_comb begin
        stepped = nib_step(cur.dpl, dec.op == OP_DEC);
        nxt  = cur;
        w_we = 1'b0;
        h_we = 1'b0;
        l_we = 1'b0;
        w_wd = cur.ac;
        h_wd = cur.dph;
        l_wd = cur.dpl;
        case (dec.op)
            OP_LDZ: begin
                nxt.dph = '0;
                nxt.dpl = dec.imm;
            end
            OP_LHI:   nxt.dph = dec.imm;
            OP_INC, OP_DEC: begin
                nxt.dpl = stepped;
                nxt.zf  = nib_is_zero(stepped);
            end
            OP_AC2DL: nxt.dpl = cur.ac;
            OP_DL2AC: begin
                nxt.ac = cur.dpl;
                nxt.zf = nib_is_zero(cur.dpl);
            end
            OP_XAH: begin
                nxt.ac  = cur.dph;
                nxt.dph = cur.ac;
            end
            OP_XAW: begin
                nxt.ac = w_rd;
                w_we   = 1'b1;
            end
            OP_XHS: begin
                nxt.dph = h_rd;
                h_we    = 1'b1;
            end
            OP_XLS: begin
                nxt.dpl = l_rd;
                l_we    = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dp_xchg_unit.sv
module dp_xchg_unit
    import dpx_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    instr_valid,
    input  logic [OPC_W-1:0]        opcode,
    output logic [NIB_W-1:0]        ac_out,
    output logic [NIB_W-1:0]        dph_out,
    output logic [NIB_W-1:0]        dpl_out,
    output logic [N_WORK*NIB_W-1:0] work_regs,
    output logic [N_SAVE*NIB_W-1:0] save_hi,
    output logic [N_SAVE*NIB_W-1:0] save_lo,
    output logic                    zero_flag
);

    dec_t  dec;
    core_t core_q;
    core_t core_d;
    logic  w_we, h_we, l_we;
    nib_t  w_rd, h_rd, l_rd;
    nib_t  w_wd, h_wd, l_wd;

    dpx_decoder u_dec (
        .valid (instr_valid),
        .code  (opcode),
        .dec   (dec)
    );

    dpx_exec u_exec (
        .cur  (core_q),
        .dec  (dec),
        .w_rd (w_rd),
        .h_rd (h_rd),
        .l_rd (l_rd),
        .nxt  (core_d),
        .w_we (w_we),
        .h_we (h_we),
        .l_we (l_we),
        .w_wd (w_wd),
        .h_wd (h_wd),
        .l_wd (l_wd)
    );

    dpx_bank #(.DEPTH(N_WORK), .W(NIB_W), .SEL_W(WSEL_W)) u_work (
        .clk   (clk),
        .rst   (rst),
        .we    (w_we),
        .sel   (dec.wsel),
        .wdata (w_wd),
        .rdata (w_rd),
        .flat  (work_regs)
    );

    dpx_bank #(.DEPTH(N_SAVE), .W(NIB_W), .SEL_W(SSEL_W)) u_save_h (
        .clk   (clk),
        .rst   (rst),
        .we    (h_we),
        .sel   (dec.ssel),
        .wdata (h_wd),
        .rdata (h_rd),
        .flat  (save_hi)
    );

    dpx_bank #(.DEPTH(N_SAVE), .W(NIB_W), .SEL_W(SSEL_W)) u_save_l (
        .clk   (clk),
        .rst   (rst),
        .we    (l_we),
        .sel   (dec.ssel),
        .wdata (l_wd),
        .rdata (l_rd),
        .flat  (save_lo)
    );

    always_ff @(posedge clk) begin
        if (rst) core_q <= '0;
        else     core_q <= core_d;
    end

    assign ac_out    = core_q.ac;
    assign dph_out   = core_q.dph;
    assign dpl_out   = core_q.dpl;
    assign zero_flag = core_q.zf;

endmodule

// File: rtl/dpx_checker.sv
module dpx_checker
    import dpx_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    instr_valid,
    input logic [OPC_W-1:0]        opcode,
    input logic [NIB_W-1:0]        ac_out,
    input logic [NIB_W-1:0]        dph_out,
    input logic [NIB_W-1:0]        dpl_out,
    input logic [N_WORK*NIB_W-1:0] work_regs,
    input logic [N_SAVE*NIB_W-1:0] save_hi,
    input logic [N_SAVE*NIB_W-1:0] save_lo,
    input logic                    zero_flag
);

    logic [4*NIB_W+N_WORK*NIB_W+2*N_SAVE*NIB_W-1:0] image;
    assign image = {ac_out, dph_out, dpl_out, zero_flag, work_regs, save_hi, save_lo};

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (image == '0));

    a_r2_ldz: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && opcode[7:4] == 4'b1000) |=>
            (dph_out == '0 && dpl_out == $past(opcode[3:0]) && zero_flag == $past(zero_flag)));

    a_r4_inc_wrap: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && opcode == 8'hEE) |=>
            (dpl_out == NIB_W'($past(dpl_out) + 1'b1) && zero_flag == (dpl_out == '0)));

    a_r5_dec_wrap: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && opcode == 8'hEF) |=>
            (dpl_out == NIB_W'($past(dpl_out) - 1'b1) && zero_flag == (dpl_out == '0)));

    a_r8_xah: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && opcode == 8'h23) |=>
            (ac_out == $past(dph_out) && dph_out == $past(ac_out)));

    a_r9_xaw: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && opcode[7:4] == 4'b1110 && opcode[1:0] == 2'b00) |=>
            (ac_out == $past(work_regs[NIB_W*opcode[3:2] +: NIB_W])
             && work_regs[NIB_W*$past(opcode[3:2]) +: NIB_W] == $past(ac_out)));

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> $stable(image));

    a_r13_zf_only_three: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && opcode != 8'hEE && opcode != 8'hEF && opcode != 8'hE9) |=>
            $stable(zero_flag));

endmodule

bind dp_xchg_unit dpx_checker u_dpx_checker (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .opcode      (opcode),
    .ac_out      (ac_out),
    .dph_out     (dph_out),
    .dpl_out     (dpl_out),
    .work_regs   (work_regs),
    .save_hi     (save_hi),
    .save_lo     (save_lo),
    .zero_flag   (zero_flag)
);

// File: tb/test_dp_xchg_unit.sv
`timescale 1ns/1ps
module test_dp_xchg_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [3:0]  ac_out, dph_out, dpl_out;
    logic [15:0] work_regs;
    logic [7:0]  save_hi, save_lo;
    logic        zero_flag;

    always #2.5 clk = ~clk;

    dp_xchg_unit i_dp_xchg_unit (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .opcode      (opcode),
        .ac_out      (ac_out),
        .dph_out     (dph_out),
        .dpl_out     (dpl_out),
        .work_regs   (work_regs),
        .save_hi     (save_hi),
        .save_lo     (save_lo),
        .zero_flag   (zero_flag)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference model
    logic [3:0] m_ac, m_dph, m_dpl;
    logic       m_zf;
    logic [3:0] m_w [4];
    logic [3:0] m_h [2];
    logic [3:0] m_l [2];

    logic [44:0] exp_q [$];
    string       tag_q [$];

    function automatic logic [44:0] model_image();
        return {m_ac, m_dph, m_dpl, m_zf,
                m_w[3], m_w[2], m_w[1], m_w[0],
                m_h[1], m_h[0], m_l[1], m_l[0]};
    endfunction

    function automatic logic [44:0] dut_image();
        return {ac_out, dph_out, dpl_out, zero_flag, work_regs, save_hi, save_lo};
    endfunction

    task automatic model_reset();
        m_ac = 0; m_dph = 0; m_dpl = 0; m_zf = 0;
        for (int i = 0; i < 4; i++) m_w[i] = 0;
        for (int i = 0; i < 2; i++) begin m_h[i] = 0; m_l[i] = 0; end
    endtask

    function automatic string req_of(input logic v, input logic [7:0] op);
        if (!v) return "R12";
        if (op[7:4] == 4'h8) return "R2";
        if (op[7:4] == 4'h4) return "R3";
        case (op)
            8'hEE: return "R4";
            8'hEF: return "R5";
            8'hF7: return "R6";
            8'hE9: return "R7";
            8'h23: return "R8";
            8'hE0, 8'hE4, 8'hE8, 8'hEC: return "R9";
            8'hF8, 8'hF9: return "R10";
            8'hFC, 8'hFD: return "R11";
            default: return "R13";
        endcase
    endfunction

    task automatic model_step(input logic [7:0] op);
        logic [3:0] t;
        if (op[7:4] == 4'h8) begin
            m_dph = 0; m_dpl = op[3:0];
        end else if (op[7:4] == 4'h4) begin
            m_dph = op[3:0];
        end else begin
            case (op)
                8'hEE: begin m_dpl = m_dpl + 4'd1; m_zf = (m_dpl == 0); end
                8'hEF: begin m_dpl = m_dpl - 4'd1; m_zf = (m_dpl == 0); end
                8'hF7: m_dpl = m_ac;
                8'hE9: begin m_ac = m_dpl; m_zf = (m_dpl == 0); end
                8'h23: begin t = m_ac; m_ac = m_dph; m_dph = t; end
                8'hE0, 8'hE4, 8'hE8, 8'hEC: begin
                    t = m_ac; m_ac = m_w[op[3:2]]; m_w[op[3:2]] = t;
                end
                8'hF8, 8'hF9: begin t = m_dph; m_dph = m_h[op[0]]; m_h[op[0]] = t; end
                8'hFC, 8'hFD: begin t = m_dpl; m_dpl = m_l[op[0]]; m_l[op[0]] = t; end
                default: ;
            endcase
        end
    endtask

    task automatic check(input string req, input logic [44:0] exp_v);
        total++;
        if (dut_image() !== exp_v) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, dut_image(), exp_v);
        end
    endtask

    // driver: one code per cycle, expected image pushed at the driving edge
    task automatic issue(input logic v, input logic [7:0] op);
        @(negedge clk);
        instr_valid = v;
        opcode      = op;
        if (v) model_step(op);
        exp_q.push_back(model_image());
        tag_q.push_back(req_of(v, op));
    endtask

    task automatic go_idle();
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    // monitor: result due one rising edge after the code was driven
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                automatic logic [44:0] e = exp_q.pop_front();
                automatic string       r = tag_q.pop_front();
                check(r, e);
            end
        end
    end

    function automatic logic [7:0] pick_code(input int k, input logic [3:0] n);
        case (k)
            0:  return {4'h8, n};
            1:  return {4'h4, n};
            2:  return 8'hEE;
            3:  return 8'hEF;
            4:  return 8'hF7;
            5:  return 8'hE9;
            6:  return 8'h23;
            7:  return {4'hE, n[1:0], 2'b00};
            8:  return {7'b1111100, n[0]};
            9:  return {7'b1111110, n[0]};
            10: return {4'h8, n};
            11: return 8'hEE;
            default: return 8'($urandom_range(0, 255));
        endcase
    endfunction

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", 45'h0);

        // directed
        issue(1, 8'h85);   // R2
        issue(1, 8'h4A);   // R3
        issue(1, 8'h8F);   // R2 clears high nibble
        issue(1, 8'hEE);   // R4 wrap F->0, flag set
        issue(1, 8'hEF);   // R5 wrap 0->F, flag clear
        issue(1, 8'hEF);   // R5
        issue(1, 8'hE9);   // R7 copy E
        issue(1, 8'h81);
        issue(1, 8'hEF);   // R5 reaches 0
        issue(1, 8'hE9);   // R7 copy zero sets flag
        issue(1, 8'h87);
        issue(1, 8'hE9);
        issue(1, 8'h83);
        issue(1, 8'hF7);   // R6 dpl <- ac, flag kept
        issue(1, 8'h4C);
        issue(1, 8'h23);   // R8
        for (int i = 0; i < 4; i++) begin
            issue(1, {4'h8, 4'(i + 9)});
            issue(1, 8'hE9);
            issue(1, {4'hE, 2'(i), 2'b00});   // R9 each slot
        end
        issue(1, 8'h45);
        issue(1, 8'hF8);   // R10
        issue(1, 8'h46);
        issue(1, 8'hF9);   // R10
        issue(1, 8'h82);
        issue(1, 8'hFC);   // R11
        issue(1, 8'h8D);
        issue(1, 8'hFD);   // R11
        issue(1, 8'hFD);   // R11 swap back
        issue(0, 8'hEE);   // R12 ignored
        issue(0, 8'h23);   // R12 ignored
        issue(1, 8'h00);   // R13
        issue(1, 8'hFF);   // R13
        issue(1, 8'hE1);   // R13
        issue(1, 8'hE2);   // R13
        issue(1, 8'hFA);   // R13

        // mid-run reset, R1
        go_idle();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R1", model_image());

        // random
        for (int i = 0; i < 600; i++) begin
            automatic int         k = $urandom_range(0, 15);
            automatic logic [3:0] n = 4'($urandom_range(0, 15));
            automatic logic       v = ($urandom_range(0, 9) != 0);
            issue(v, pick_code(k, n));
        end
        go_idle();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule